// File: doc/BRIEF.md
# PHY Management Register Responder

This block is the management side of an Ethernet MAC's PHY access path, paired with an emulated PHY so that driver software can probe, configure and poll a PHY without any serial management wire. Software writes a 32-bit command word that names a PHY address, a register address, an opcode and an initiate flag. A write takes its 16-bit payload from a separate write-data register. A read places its result in a read-data register.

The emulated PHY holds 32 sixteen-bit registers at one parameterised PHY address. Identity, control and advertisement registers are stored. The status, link-partner ability, speed and diagnostic registers are computed live from the link-state input and the current advertisement register. With the default advertisement, the PHY reports an autonegotiated 100 Mb/s full-duplex link. Any other PHY address behaves as an empty bus position.

Host access uses one select input for both writes and reads. Writes happen on a clock edge. Read data is combinational from the selected register.

Top module: `phy_mgmt_resp`

## Requirements
- R1: After reset, the stored PHY registers read 0x3100 at index 0, 0x0300 at index 2, 0xE400 at index 3 and 0x01E1 at index 4. The read-data register reads 0, the write-data register reads 0 and the command register reads 0x80.
- R2: Host select encoding: 0 is the command register, 1 is the write-data register (low 16 bits) and 2 is the read-data register (low 16 bits). Select 3 reads 0. In a command word, bits 28:24 are the PHY address, bits 20:16 the register address, bits 15:14 the opcode and bit 11 initiate. A command written with initiate clear performs no access.
- R3: Opcode 1 with initiate writes the write-data register into the addressed PHY register on the edge that accepts the command.
- R4: Opcode 2 with initiate loads the read-data register on the edge that accepts the command. Opcodes 0 and 3 leave both the read-data register and the PHY registers unchanged.
- R5: A read of the command register returns the last word written to it, with bit 7 forced to 1.
- R6: A command to any PHY address other than the parameter PHY_ADDR (default 7) reads 0xFFFF and never changes the PHY registers.
- R7: Register 1 reads 0x782E while the link is up and 0 while it is down. Bits 14, 13, 12, 11, 5, 3, 2 and 1 are set when the link is up.
- R8: Register 5 reads 0x4001 plus bits 8:5 of register 4.
- R9: Register 17 reads 0x8000 whatever has been written to it.
- R10: Register 18 has bit 10 set when register 4 bit 7 or bit 8 is set, and bit 11 set when register 4 bit 8 or bit 6 is set. All other bits are 0, and the whole register reads 0 while the link is down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| link_up_i | input | 1 | Emulated PHY link state, 1 = up |
| sel_i | input | 2 | Host register select for read and write |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 32 | Host write data |
| rd_data_o | output | 32 | Host read data of the selected register |

## Verification
A bad field decode or a bad address match shows up as a wrong read-data value on the first read of the read-data register after the command edge. A stored register that is corrupted stays silent until it is read back, so every write is followed by a read of the same index and of a neighbouring index. The live registers are checked after each change to the advertisement register and to the link state, because a stale or mis-sliced copy only shows at that point.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned HOST_W  = 32;
  localparam int unsigned PHY_AW  = 5;
  localparam int unsigned REG_AW  = 5;

  // command word field positions
  localparam int unsigned PHY_LSB = 24;
  localparam int unsigned REG_LSB = 16;
  localparam int unsigned OP_LSB  = 14;
  localparam int unsigned GO_BIT  = 11;
  localparam int unsigned RDY_BIT = 7;

  // register indices with special behaviour
  localparam int unsigned STATUS_IDX  = 1;
  localparam int unsigned ADV_IDX     = 4;
  localparam int unsigned PARTNER_IDX = 5;
  localparam int unsigned SPEED_IDX   = 17;
  localparam int unsigned DIAG_IDX    = 18;

  typedef enum logic [1:0] {
    OP_NOP0 = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2,
    OP_NOP3 = 2'd3
  } mgmt_op_e;

  typedef enum logic [1:0] {
    SEL_CMD   = 2'd0,
    SEL_WDATA = 2'd1,
    SEL_RDATA = 2'd2,
    SEL_NONE  = 2'd3
  } host_sel_e;

  typedef struct packed {
    logic [PHY_AW-1:0] phy_addr;
    logic [REG_AW-1:0] reg_addr;
    mgmt_op_e          op;
    logic              go;
  } mgmt_cmd_t;

  function automatic logic [DATA_W-1:0] reg_rst_val(int unsigned idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0300;
      3:       return 16'hE400;
      ADV_IDX: return 16'h01E1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/phy_mgmt_cmd_dec.sv
module phy_mgmt_cmd_dec
  import phy_mgmt_pkg::*;
(
  input  logic [HOST_W-1:0] word_i,
  output mgmt_cmd_t         cmd_o
);
  always_comb begin
    cmd_o.phy_addr = word_i[PHY_LSB +: PHY_AW];
    cmd_o.reg_addr = word_i[REG_LSB +: REG_AW];
    cmd_o.op       = mgmt_op_e'(word_i[OP_LSB +: 2]);
    cmd_o.go       = word_i[GO_BIT];
  end
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_up_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned NUM_REGS = 1 << REG_AW;

  logic [DATA_W-1:0] mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[g] <= reg_rst_val(g);
      else if (we_i && addr_i == REG_AW'(g))
        mem_q[g] <= wdata_i;
    end
  end

  logic [DATA_W-1:0] adv;
  logic              adv_100, adv_fdx;

  assign adv     = mem_q[ADV_IDX];
  assign adv_100 = adv[7] | adv[8];
  assign adv_fdx = adv[8] | adv[6];

  always_comb begin
    unique case (addr_i)
      REG_AW'(STATUS_IDX):  rdata_o = link_up_i ? 16'h782E : '0;
      REG_AW'(PARTNER_IDX): rdata_o = 16'h4001 | (adv & 16'h01E0);
      REG_AW'(SPEED_IDX):   rdata_o = 16'h8000;
      REG_AW'(DIAG_IDX):    rdata_o = link_up_i ? {4'b0, adv_fdx, adv_100, 10'b0} : '0;
      default:              rdata_o = mem_q[addr_i];
    endcase
  end
endmodule

// File: rtl/phy_mgmt_resp.sv
module phy_mgmt_resp
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned PHY_ADDR = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_up_i,
  input  logic [1:0]        sel_i,
  input  logic              wr_en_i,
  input  logic [HOST_W-1:0] wr_data_i,
  output logic [HOST_W-1:0] rd_data_o
);
  localparam logic [PHY_AW-1:0] OWN_ADDR = PHY_AW'(PHY_ADDR);

  logic [HOST_W-1:0] cmd_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rf_rdata;
  mgmt_cmd_t         cmd;
  logic              cmd_wr, hit, phy_we, rd_load;

  phy_mgmt_cmd_dec u_dec (
    .word_i (wr_data_i),
    .cmd_o  (cmd)
  );

  assign cmd_wr  = wr_en_i && host_sel_e'(sel_i) == SEL_CMD;
  assign hit     = cmd.phy_addr == OWN_ADDR;
  assign phy_we  = cmd_wr && cmd.go && cmd.op == OP_WR && hit;
  assign rd_load = cmd_wr && cmd.go && cmd.op == OP_RD;

  phy_mgmt_regfile u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .link_up_i (link_up_i),
    .we_i      (phy_we),
    .addr_i    (cmd.reg_addr),
    .wdata_i   (wdata_q),
    .rdata_o   (rf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (cmd_wr) cmd_q <= wr_data_i;
      if (wr_en_i && host_sel_e'(sel_i) == SEL_WDATA) wdata_q <= wr_data_i[DATA_W-1:0];
      // empty bus position floats high
      if (rd_load) rdata_q <= hit ? rf_rdata : '1;
    end
  end

  always_comb begin
    unique case (host_sel_e'(sel_i))
      SEL_CMD: begin
        rd_data_o          = cmd_q;
        rd_data_o[RDY_BIT] = 1'b1;
      end
      SEL_WDATA: rd_data_o = {{(HOST_W-DATA_W){1'b0}}, wdata_q};
      SEL_RDATA: rd_data_o = {{(HOST_W-DATA_W){1'b0}}, rdata_q};
      default:   rd_data_o = '0;
    endcase
  end

  // R5
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr |=> cmd_q == $past(wr_data_i));

  // R6
  empty_addr_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_load && !hit) |=> rdata_q == 16'hFFFF);

  // R4
  nop_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && (cmd.op == OP_NOP0 || cmd.op == OP_NOP3 || !cmd.go)) |=> $stable(rdata_q));

  // R9
  speed_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_load && hit && cmd.reg_addr == REG_AW'(SPEED_IDX)) |=> rdata_q == 16'h8000);

  // R7
  link_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_load && hit && cmd.reg_addr == REG_AW'(STATUS_IDX) && !link_up_i) |=> rdata_q == '0);
endmodule

// File: tb/phy_mgmt_resp_tb_top.sv
module phy_mgmt_resp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b1;
  logic [1:0]  sel = 2'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  int          errs = 0, checks = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  phy_mgmt_resp #(.PHY_ADDR(7)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .link_up_i (link_up),
    .sel_i     (sel),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    sel = s; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_rd(logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    sel = s;
    #1 d = rd_data;
  endtask

  function automatic logic [31:0] cmd_word(int phy, int rg, int op, bit go);
    return (32'(phy) << 24) | (32'(rg) << 16) | (32'(op) << 14) | (32'(go) << 11);
  endfunction

  task automatic phy_rd(int phy, int rg, output logic [15:0] v);
    logic [31:0] d;
    host_wr(2'd0, cmd_word(phy, rg, 2, 1'b1));
    host_rd(2'd2, d);
    v = d[15:0];
  endtask

  task automatic phy_wr(int phy, int rg, logic [15:0] v);
    host_wr(2'd1, {16'h0, v});
    host_wr(2'd0, cmd_word(phy, rg, 1, 1'b1));
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [15:0] v;
    host_rd(2'd2, d); chk("R1 rdata", d, 32'h0);
    host_rd(2'd1, d); chk("R1 wdata", d, 32'h0);
    host_rd(2'd0, d); chk("R1 cmd", d, 32'h80);
    phy_rd(7, 0, v); chk("R1 reg0", 32'(v), 32'h3100);
    phy_rd(7, 2, v); chk("R1 reg2", 32'(v), 32'h0300);
    phy_rd(7, 3, v); chk("R1 reg3", 32'(v), 32'hE400);
    phy_rd(7, 4, v); chk("R1 reg4", 32'(v), 32'h01E1);
  endtask

  task automatic t_cmd_readback;
    logic [31:0] d;
    host_wr(2'd0, 32'h1234_0001);
    host_rd(2'd0, d); chk("R5 readback", d, 32'h1234_0081);
    host_rd(2'd3, d); chk("R2 sel3", d, 32'h0);
  endtask

  task automatic t_no_initiate;
    logic [31:0] d; logic [15:0] v;
    phy_rd(7, 3, v);
    host_wr(2'd1, 32'h0000_AAAA);
    host_wr(2'd0, cmd_word(7, 0, 1, 1'b0));
    host_wr(2'd0, cmd_word(7, 0, 2, 1'b0));
    host_rd(2'd2, d); chk("R2 no-go read", d, 32'hE400);
    phy_rd(7, 0, v); chk("R2 no-go write", 32'(v), 32'h3100);
  endtask

  task automatic t_write;
    logic [15:0] v;
    phy_wr(7, 9, 16'hBEEF);
    phy_wr(7, 31, 16'h1357);
    phy_rd(7, 9, v);  chk("R3 reg9", 32'(v), 32'hBEEF);
    phy_rd(7, 31, v); chk("R3 reg31", 32'(v), 32'h1357);
    phy_rd(7, 8, v);  chk("R3 neighbour", 32'(v), 32'h0);
  endtask

  task automatic t_nop_ops;
    logic [31:0] d; logic [15:0] v;
    phy_rd(7, 9, v);
    host_wr(2'd1, 32'h0000_5555);
    host_wr(2'd0, cmd_word(7, 9, 0, 1'b1));
    host_rd(2'd2, d); chk("R4 op0 rdata", d, 32'hBEEF);
    host_wr(2'd0, cmd_word(7, 3, 3, 1'b1));
    host_rd(2'd2, d); chk("R4 op3 rdata", d, 32'hBEEF);
    phy_rd(7, 9, v); chk("R4 op0 no write", 32'(v), 32'hBEEF);
  endtask

  task automatic t_empty_addr;
    logic [15:0] v;
    phy_rd(6, 9, v);  chk("R6 phy6", 32'(v), 32'hFFFF);
    phy_rd(31, 0, v); chk("R6 phy31", 32'(v), 32'hFFFF);
    phy_wr(6, 9, 16'h0000);
    phy_rd(7, 9, v);  chk("R6 write ignored", 32'(v), 32'hBEEF);
  endtask

  task automatic t_live;
    logic [15:0] v;
    phy_rd(7, 1, v);  chk("R7 link up", 32'(v), 32'h782E);
    phy_rd(7, 5, v);  chk("R8 default", 32'(v), 32'h41E1);
    phy_rd(7, 18, v); chk("R10 default", 32'(v), 32'h0C00);
    phy_rd(7, 17, v); chk("R9 speed", 32'(v), 32'h8000);
    phy_wr(7, 17, 16'h1234);
    phy_rd(7, 17, v); chk("R9 after write", 32'(v), 32'h8000);
    phy_wr(7, 4, 16'h0041);
    phy_rd(7, 5, v);  chk("R8 10fdx", 32'(v), 32'h4041);
    phy_rd(7, 18, v); chk("R10 10fdx", 32'(v), 32'h0800);
    phy_wr(7, 4, 16'h0081);
    phy_rd(7, 5, v);  chk("R8 100hdx", 32'(v), 32'h4081);
    phy_rd(7, 18, v); chk("R10 100hdx", 32'(v), 32'h0400);
    phy_wr(7, 4, 16'h0021);
    phy_rd(7, 18, v); chk("R10 10hdx", 32'(v), 32'h0000);
    phy_wr(7, 4, 16'h0101);
    phy_rd(7, 18, v); chk("R10 100fdx", 32'(v), 32'h0C00);
    link_up = 1'b0;
    phy_rd(7, 1, v);  chk("R7 link down", 32'(v), 32'h0);
    phy_rd(7, 18, v); chk("R10 link down", 32'(v), 32'h0);
    link_up = 1'b1;
    phy_rd(7, 1, v);  chk("R7 link back", 32'(v), 32'h782E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_cmd_readback;
    t_no_initiate;
    t_write;
    t_nop_ops;
    t_empty_addr;
    t_live;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule